// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a small read-only cache that sits between a processor load port and a slower backing memory. Each cache block holds one data word. A request names a block address. The low bits of that address choose a set, which is the address modulo the set count. The remaining bits are the tag. The two entries of the chosen set are compared in parallel. A 2-to-1 selector then delivers the data of the matching entry.

When neither entry matches, the block issues a single read to the backing memory and stays busy until the word comes back. It then installs the word in one entry of the set and returns it to the requester. One bit per set records which entry was used last. An empty entry is always filled before any valid one is replaced, with entry 0 taken first. When both entries are valid, the entry not named by that bit is replaced.

The request side has a single outstanding access. A new request is taken only while `req_ready` is high, and each accepted request produces exactly one response pulse.

Top module: `cache2w_top`

## Requirements
- R1: After reset every entry is invalid. `req_ready` is 1, `rsp_valid` is 0 and `mem_rd` is 0, and the first access to any address is a miss.
- R2: The set is the block address modulo SETS, meaning the low log2(SETS) bits. The tag is the remaining upper bits. Two addresses with equal low bits and different tags can both be resident, each in its own entry of that set.
- R3: An accepted request that hits gives `rsp_valid`=1, `rsp_hit`=1 and the stored word on `rsp_data` in the cycle after acceptance. It issues no memory read.
- R4: An accepted request that misses raises `mem_rd` for exactly one cycle, in the cycle after acceptance, with `mem_addr` equal to the block address. It keeps `req_ready` low until `mem_ack`. In the cycle after `mem_ack` it gives `rsp_valid`=1, `rsp_hit`=0 and the returned word.
- R5: A word brought in by a miss is installed, so the next access to the same address hits and returns that word.
- R6: A fill goes into an invalid entry of the set when one exists, entry 0 before entry 1. Only when both entries are valid does the recency bit choose the victim.
- R7: The per-set recency bit is set to the entry just used on every hit and every fill. A miss with both entries valid replaces the other entry. With SETS=2, the block sequence 0, 8, 0, 6, 8 gives miss, miss, hit, miss, miss. After it, 6 hits and 0 misses.
- R8: A request presented while `req_ready` is 0 is ignored. It causes no memory read, no response and no fill.
- R9: Fills and recency updates in one set leave the contents of the other sets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Block address of the request |
| req_ready | output | 1 | Cache idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Response came from a hit (1) or a fill (0) |
| rsp_data | output | DATA_W | Returned word |
| mem_rd | output | 1 | One-cycle read command to backing memory |
| mem_addr | output | ADDR_W | Block address to read |
| mem_ack | input | 1 | Backing memory returns the word this cycle |
| mem_data | input | DATA_W | Word returned by backing memory |

## Verification
The assertions assume that the backing memory answers each `mem_rd` with exactly one `mem_ack` pulse. They also assume that `mem_ack` never arrives while the cache is idle or in the same cycle as the read command. The bench memory model meets both conditions: it captures each read command and pulses `mem_ack` once, a fixed number of cycles later. The requester side is left unconstrained on purpose. The bench holds `req_valid` high through a busy window to show that such requests are dropped, and it never starts a new access before the previous response has been seen.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
   localparam int C2W_WAYS = 2;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } c2w_state_e;

   function automatic bit c2w_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
   parameter int SETS   = 2,
   parameter int IDX_W  = 1,
   parameter int TAG_W  = 5,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  set_i,
   input  logic [TAG_W-1:0]  tag_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              hit_o,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o
);
   logic [SETS-1:0]   vld_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] word_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (wr_en_i) begin
         vld_q[set_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         tag_q[set_i]  <= tag_i;
         word_q[set_i] <= wr_data_i;
      end
   end

   assign valid_o = vld_q[set_i];
   assign hit_o   = vld_q[set_i] && (tag_q[set_i] == tag_i);
   assign data_o  = word_q[set_i];
endmodule

// File: rtl/cache2w_repl.sv
module cache2w_repl #(
   parameter int SETS  = 2,
   parameter int IDX_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] set_i,
   input  logic [1:0]       valid_i,
   input  logic             touch_i,
   input  logic             touch_way_i,
   output logic             victim_o
);
   logic [SETS-1:0] mru_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mru_q <= '0;
      end else if (touch_i) begin
         mru_q[set_i] <= touch_way_i;
      end
   end

   always_comb begin
      if (!valid_i[0])      victim_o = 1'b0;
      else if (!valid_i[1]) victim_o = 1'b1;
      else                  victim_o = ~mru_q[set_i];
   end

   // R7: once both entries are valid, the victim is never the entry touched on the previous cycle
   p_victim_not_mru_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_i && $stable(set_i)) |=> ((&valid_i) -> (victim_o != $past(touch_way_i))));
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
   import cache2w_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 16,
   parameter int SETS   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_data
);
   localparam int SET_BITS = $clog2(SETS);
   localparam int IDX_W    = (SET_BITS == 0) ? 1 : SET_BITS;
   localparam int TAG_W    = ADDR_W - SET_BITS;

   if (!c2w_is_pow2(SETS)) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W must exceed log2(SETS)");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   c2w_state_e        state_q;
   logic [ADDR_W-1:0] pend_q;
   logic              mem_rd_q, rsp_valid_q, rsp_hit_q;
   logic [DATA_W-1:0] rsp_data_q;

   logic [ADDR_W-1:0] lk_addr;
   logic [IDX_W-1:0]  lk_set;
   logic [TAG_W-1:0]  lk_tag;
   logic [1:0]        way_hit, way_vld, way_we;
   logic [DATA_W-1:0] way_data [C2W_WAYS];
   logic              accept, hit_any, fill, victim, touch, touch_way;
   logic [DATA_W-1:0] hit_data;

   assign lk_addr = (state_q == ST_IDLE) ? req_addr : pend_q;

   if (SETS == 1) begin : g_single_set
      assign lk_set = '0;
      assign lk_tag = lk_addr;
   end else begin : g_multi_set
      assign lk_set = lk_addr[SET_BITS-1:0];
      assign lk_tag = lk_addr[ADDR_W-1:SET_BITS];
   end

   assign accept  = req_valid && (state_q == ST_IDLE);
   assign hit_any = |way_hit;
   assign fill    = (state_q == ST_WAIT) && mem_ack;

   for (genvar w = 0; w < C2W_WAYS; w++) begin : g_way
      assign way_we[w] = fill && (victim == w[0]);
      cache2w_way #(
         .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
      ) u_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_i    (lk_set),
         .tag_i    (lk_tag),
         .wr_en_i  (way_we[w]),
         .wr_data_i(mem_data),
         .hit_o    (way_hit[w]),
         .valid_o  (way_vld[w]),
         .data_o   (way_data[w])
      );
   end

   assign hit_data  = way_hit[1] ? way_data[1] : way_data[0];
   assign touch     = (accept && hit_any) || fill;
   assign touch_way = fill ? victim : way_hit[1];

   cache2w_repl #(.SETS(SETS), .IDX_W(IDX_W)) u_repl (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (lk_set),
      .valid_i    (way_vld),
      .touch_i    (touch),
      .touch_way_i(touch_way),
      .victim_o   (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pend_q      <= '0;
         mem_rd_q    <= 1'b0;
         rsp_valid_q <= 1'b0;
         rsp_hit_q   <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         mem_rd_q    <= 1'b0;
         rsp_valid_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (accept) begin
               if (hit_any) begin
                  rsp_valid_q <= 1'b1;
                  rsp_hit_q   <= 1'b1;
                  rsp_data_q  <= hit_data;
               end else begin
                  pend_q   <= req_addr;
                  mem_rd_q <= 1'b1;
                  state_q  <= ST_WAIT;
               end
            end
            ST_WAIT: if (mem_ack) begin
               rsp_valid_q <= 1'b1;
               rsp_hit_q   <= 1'b0;
               rsp_data_q  <= mem_data;
               state_q     <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_valid = rsp_valid_q;
   assign rsp_hit   = rsp_hit_q;
   assign rsp_data  = rsp_data_q;
   assign mem_rd    = mem_rd_q;
   assign mem_addr  = pend_q;

   // R2: one tag is never resident twice in a set
   p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(way_hit));
   // R3: a hit answers on the next cycle
   p_hit_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && hit_any) |=> (rsp_valid && rsp_hit));
   // R4: a miss issues a read and no response on the next cycle
   p_miss_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !hit_any) |=> (mem_rd && !rsp_valid && !req_ready));
   // R4: the read command lasts a single cycle
   p_rd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);
   // R4: memory answers only while a miss is outstanding
   p_ack_waiting_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ack |-> (state_q == ST_WAIT));
   // R6: a fill into a set with an empty entry 0 uses entry 0
   p_fill_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill && !way_vld[0]) |-> way_we[0]);
   // R8: nothing is accepted while a miss is outstanding
   p_busy_no_resp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_WAIT) && !mem_ack) |=> !rsp_valid);
endmodule

// File: tb/tb_cache2w_top.sv
`timescale 1ns/1ps
module tb_cache2w_top;
   localparam int AW = 6;
   localparam int DW = 16;
   localparam int NS = 2;
   localparam int MEM_LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic req_ready, rsp_valid, rsp_hit, mem_rd;
   logic [DW-1:0] rsp_data;
   logic [AW-1:0] mem_addr;
   logic mem_ack = 1'b0;
   logic [DW-1:0] mem_data = '0;

   int n_chk = 0, n_bad = 0, rd_count = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cache2w_top #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_data(rsp_data), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_data(mem_data)
   );

   function automatic logic [DW-1:0] mword(input logic [AW-1:0] a);
      return (16'(a) * 16'd1021) ^ 16'h3C5A;
   endfunction

   // backing memory with fixed latency
   logic          pend = 1'b0;
   int            cnt = 0;
   logic [AW-1:0] cap_addr = '0;
   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (!rst_n) begin
         pend <= 1'b0;
      end else if (mem_rd) begin
         pend     <= 1'b1;
         cnt      <= MEM_LAT - 1;
         cap_addr <= mem_addr;
         rd_count <= rd_count + 1;
      end else if (pend) begin
         if (cnt == 0) begin
            mem_ack  <= 1'b1;
            mem_data <= mword(cap_addr);
            pend     <= 1'b0;
         end else begin
            cnt <= cnt - 1;
         end
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                      input string rq, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic access(input logic [AW-1:0] a, input bit exp_hit, input string rq);
      int rd0, n;
      rd0 = rd_count;
      @(negedge clk);
      chk(32'(req_ready), 1, rq, "ready before request");
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
      if (exp_hit) begin
         chk(32'(rsp_valid), 1, rq, "hit response next cycle");
         chk(32'(rsp_hit), 1, rq, "hit flag");
         chk(32'(rsp_data), 32'(mword(a)), rq, "hit data");
         chk(32'(mem_rd), 0, rq, "no read on hit");
      end else begin
         chk(32'(rsp_valid), 0, rq, "no early response on miss");
         chk(32'(mem_rd), 1, rq, "read issued on miss");
         chk(32'(mem_addr), 32'(a), rq, "read address");
         chk(32'(req_ready), 0, rq, "busy during miss");
         n = 0;
         while (!rsp_valid && n < 40) begin
            @(negedge clk);
            n++;
         end
         chk(32'(rsp_valid), 1, rq, "miss response");
         chk(32'(rsp_hit), 0, rq, "miss flag");
         chk(32'(rsp_data), 32'(mword(a)), rq, "fill data");
         chk(32'(rd_count - rd0), 1, rq, "one read per miss");
      end
   endtask

   task automatic t_reset();
      do_reset();
      chk(32'(req_ready), 1, "R1", "ready after reset");
      chk(32'(rsp_valid), 0, "R1", "no response after reset");
      chk(32'(mem_rd), 0, "R1", "no read after reset");
      access(6'd5, 1'b0, "R1");
      access(6'd5, 1'b1, "R5");
   endtask

   task automatic t_example();
      do_reset();
      access(6'd0, 1'b0, "R7");
      access(6'd8, 1'b0, "R7");
      access(6'd0, 1'b1, "R7");
      access(6'd6, 1'b0, "R7");
      access(6'd8, 1'b0, "R7");
      access(6'd6, 1'b1, "R7");
      access(6'd0, 1'b0, "R7");
   endtask

   task automatic t_two_tags();
      do_reset();
      access(6'd1, 1'b0, "R2");
      access(6'd3, 1'b0, "R6");
      access(6'd1, 1'b1, "R2");
      access(6'd3, 1'b1, "R6");
      access(6'd3, 1'b1, "R3");
      access(6'd5, 1'b0, "R7");
      access(6'd3, 1'b1, "R7");
      access(6'd1, 1'b0, "R7");
   endtask

   task automatic t_sets_apart();
      do_reset();
      access(6'd9, 1'b0, "R9");
      access(6'd0, 1'b0, "R9");
      access(6'd2, 1'b0, "R9");
      access(6'd4, 1'b0, "R9");
      access(6'd9, 1'b1, "R9");
   endtask

   task automatic t_busy_ignored();
      int rd0, n;
      do_reset();
      rd0 = rd_count;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 6'd0;
      @(negedge clk);
      req_addr = 6'd12;
      n = 0;
      while (!rsp_valid && n < 40) begin
         @(negedge clk);
         n++;
      end
      req_valid = 1'b0;
      chk(32'(rsp_data), 32'(mword(6'd0)), "R8", "response belongs to first request");
      @(negedge clk);
      chk(32'(rsp_valid), 0, "R8", "no response for dropped request");
      chk(32'(mem_rd), 0, "R8", "no read for dropped request");
      chk(32'(rd_count - rd0), 1, "R8", "single read");
      access(6'd0, 1'b1, "R5");
      access(6'd12, 1'b0, "R8");
   endtask

   initial begin
      t_reset();
      t_example();
      t_two_tags();
      t_sets_apart();
      t_busy_ignored();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule